// File: doc/BRIEF.md
# Alarm Status and Alarm Pin Controller

This block gathers the three alarm conditions of a multi-channel DAC controller and presents them in two ways: as a read-only 16-bit status word and as a single active-high alarm pin. The three conditions are an over-temperature flag (die above +140 °C), a frame CRC error flag and a DAC-busy flag. The temperature sensor and the CRC checker sit outside this block. They deliver raw event levels or pulses. A separate configuration block supplies the per-source enable bits and a one-cycle clear strobe, which comes from the alarm-reset bit of the trigger register.

The thermal and CRC alarms are sticky. They stay set after their source goes away, until software clears them. The busy alarm is live: it tracks the update activity and drops on its own, and the clear strobe leaves it alone. The alarm pin is the OR of each alarm ANDed with its enable. A latched thermal alarm also drives a forced power-down request to every DAC output stage, and the thermal enable has no influence on that request.

The reset is asynchronous, active low, and its release passes through a synchronizer. In the configuration block the enables reset to thermal = 1, busy = 0 and CRC = 1. Here they are plain inputs.

Top module: `alarm_status_top`

## Requirements
- R1: While reset is applied and after it is released, the status word, `alarm_o` and `force_pd_o` are all 0 until an event arrives.
- R2: Status bit 0 is the thermal alarm, bit 1 is the busy alarm and bit 2 is the CRC alarm. Bits 15 to 3 always read 0.
- R3: If `temp_over_i` is high at a rising clock edge, status bit 0 is 1 after that edge. It stays 1 after the input falls, until a clear.
- R4: If `crc_err_i` is high at a rising clock edge, status bit 2 is 1 after that edge. It stays 1 after the input falls, until a clear.
- R5: Status bit 1 equals the `busy_i` value sampled at the previous rising edge, so it releases by itself. `alm_clear_i` has no effect on it.
- R6: If `alm_clear_i` is high at a rising edge, status bits 0 and 2 are 0 after that edge, unless their own event is also high at that edge.
- R7: If an event and `alm_clear_i` are both high at the same edge, the event wins and that alarm is 1 after the edge.
- R8: `alarm_o` = (bit0 & `en_temp_i`) | (bit1 & `en_busy_i`) | (bit2 & `en_crc_i`). A change of an enable shows on `alarm_o` without a clock edge.
- R9: `force_pd_o` equals status bit 0 at all times, whatever the value of `en_temp_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| temp_over_i | input | 1 | Over-temperature event from the sensor |
| crc_err_i | input | 1 | Frame CRC error event |
| busy_i | input | 1 | DAC update in progress |
| en_temp_i | input | 1 | Thermal alarm pin enable |
| en_busy_i | input | 1 | Busy alarm pin enable |
| en_crc_i | input | 1 | CRC alarm pin enable |
| alm_clear_i | input | 1 | Clear strobe for the latched alarms |
| status_o | output | 16 | Read-only status word |
| alarm_o | output | 1 | Active-high alarm pin |
| force_pd_o | output | 1 | Forced power-down request to the output stages |

## Verification
A latched alarm that drops without a clear, or that survives one, shows on the next sampled status word. Through `force_pd_o`, a thermal fault is also visible on the power-down request in the same cycle. A busy flag that stays stuck breaks the one-cycle following relation at the very next edge. Because the pin is a combinational mask of the status bits, a wrong mask shows on `alarm_o` as soon as the enables change, without waiting for a clock edge. Random stimulus mixes events, clears and enables every cycle, so each of these mismatches is caught within one cycle of the edge where it first goes wrong.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int STATUS_W = 16;
  localparam int NUM_SRC  = 3;
  // status bit positions; software decodes these
  localparam int IDX_TEMP = 0;
  localparam int IDX_BUSY = 1;
  localparam int IDX_CRC  = 2;
  // 1 = sticky source, 0 = live source
  localparam logic [NUM_SRC-1:0] LATCH_MASK = 3'b101;
endpackage

// File: rtl/alm_rst_sync.sv
module alm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alm_cell.sv
module alm_cell #(
  parameter bit LATCHED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_i,
  input  logic clr_i,
  output logic state_o
);
  logic state_q;
  logic state_d;
  logic state_en;

  generate
    if (LATCHED) begin : g_sticky
      always_comb begin
        state_d = ev_i | (state_q & ~clr_i);
      end
    end else begin : g_live
      always_comb begin
        state_d = ev_i;
      end
    end
  endgenerate

  always_comb begin
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= 1'b0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  generate
    if (LATCHED) begin : g_sticky_chk
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q && !clr_i |=> state_q); // R3
      AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i && clr_i |=> state_q); // R7
      AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !ev_i |=> !state_q); // R6
    end else begin : g_live_chk
      AST_LIVE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_i |=> !state_q); // R5
      AST_LIVE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> state_q); // R5
    end
  endgenerate
endmodule

// File: rtl/alm_combine.sv
module alm_combine
  import alm_pkg::*;
#(
  parameter int SW = STATUS_W,
  parameter int NS = NUM_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] state_i,
  input  logic [NS-1:0] en_i,
  output logic [SW-1:0] status_o,
  output logic          alarm_o,
  output logic          force_pd_o
);
  logic [NS-1:0] masked;

  genvar g;
  generate
    for (g = 0; g < SW; g++) begin : g_status
      if (g < NS) begin : g_src
        assign status_o[g] = state_i[g];
        assign masked[g]   = state_i[g] & en_i[g];
      end else begin : g_rsvd
        assign status_o[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    alarm_o    = |masked;
    force_pd_o = state_i[IDX_TEMP];
  end

  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_o |-> !(status_o[IDX_TEMP] && en_i[IDX_TEMP]) &&
                 !(status_o[IDX_CRC] && en_i[IDX_CRC]) &&
                 !(status_o[IDX_BUSY] && en_i[IDX_BUSY])); // R8
  AST_PD_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    force_pd_o == status_o[IDX_TEMP]); // R9
endmodule

// File: rtl/alarm_status_top.sv
module alarm_status_top
  import alm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                temp_over_i,
  input  logic                crc_err_i,
  input  logic                busy_i,
  input  logic                en_temp_i,
  input  logic                en_busy_i,
  input  logic                en_crc_i,
  input  logic                alm_clear_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                alarm_o,
  output logic                force_pd_o
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] ev_vec;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] state_vec;

  always_comb begin
    ev_vec           = '0;
    ev_vec[IDX_TEMP] = temp_over_i;
    ev_vec[IDX_BUSY] = busy_i;
    ev_vec[IDX_CRC]  = crc_err_i;
    en_vec           = '0;
    en_vec[IDX_TEMP] = en_temp_i;
    en_vec[IDX_BUSY] = en_busy_i;
    en_vec[IDX_CRC]  = en_crc_i;
  end

  alm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  genvar s;
  generate
    for (s = 0; s < NUM_SRC; s++) begin : g_src
      alm_cell #(.LATCHED(LATCH_MASK[s])) u_cell (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .ev_i    (ev_vec[s]),
        .clr_i   (alm_clear_i),
        .state_o (state_vec[s])
      );
    end
  endgenerate

  alm_combine #(.SW(STATUS_W), .NS(NUM_SRC)) u_comb (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .state_i    (state_vec),
    .en_i       (en_vec),
    .status_o   (status_o),
    .alarm_o    (alarm_o),
    .force_pd_o (force_pd_o)
  );

  AST_CRC_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    crc_err_i |=> status_o[IDX_CRC]); // R4
  AST_BUSY_IGNORES_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_i && alm_clear_i |=> status_o[IDX_BUSY]); // R5
endmodule

// File: tb/alarm_status_top_tb_top.sv
module alarm_status_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic temp_i, crc_i, busy_i, en_t, en_b, en_c, clr;
  logic [15:0] status;
  logic alarm, pd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic m_temp, m_crc, m_busy;

  always #10 clk = ~clk;

  alarm_status_top dut_i (
    .clk(clk), .rst_n(rst_n), .temp_over_i(temp_i), .crc_err_i(crc_i),
    .busy_i(busy_i), .en_temp_i(en_t), .en_busy_i(en_b), .en_crc_i(en_c),
    .alm_clear_i(clr), .status_o(status), .alarm_o(alarm), .force_pd_o(pd)
  );

  function automatic logic [15:0] exp_status();
    return {13'd0, m_crc, m_busy, m_temp};
  endfunction

  function automatic logic exp_alarm();
    return (m_temp & en_t) | (m_busy & en_b) | (m_crc & en_c);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " status"}, status, exp_status());
    chk({req, " alarm"}, {15'd0, alarm}, {15'd0, exp_alarm()});
    chk({req, " pd R9"}, {15'd0, pd}, {15'd0, m_temp});
  endtask

  // drive at negedge, clock once, update model, sample at next negedge
  task automatic step(input logic t, input logic c, input logic b, input logic cl);
    temp_i = t; crc_i = c; busy_i = b; clr = cl;
    @(posedge clk);
    m_temp = t | (m_temp & ~cl);
    m_crc  = c | (m_crc & ~cl);
    m_busy = b;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    temp_i = 0; crc_i = 0; busy_i = 0; clr = 0;
    en_t = 1; en_b = 0; en_c = 1;
    m_temp = 0; m_crc = 0; m_busy = 0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    // R3 thermal latches and holds
    step(1, 0, 0, 0);
    chk("R3 set", status, 16'h0001);
    chk("R2 thermal at bit0", status & 16'hfffe, 16'h0000);
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R3 hold", status, 16'h0001);
    chk("R9 pd on", {15'd0, pd}, 16'h0001);
    chk("R8 pin thermal", {15'd0, alarm}, 16'h0001);
    en_t = 0; #1;
    chk("R8 mask thermal", {15'd0, alarm}, 16'h0000);
    chk("R9 pd ignores enable", {15'd0, pd}, 16'h0001);
    en_t = 1;
    @(negedge clk);

    // R6 clear
    step(0, 0, 0, 1);
    chk("R6 cleared", status, 16'h0000);
    chk("R9 pd off", {15'd0, pd}, 16'h0000);

    // R4 CRC latch, R2 at bit 2
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R4 hold", status, 16'h0004);

    // R7 event beats clear
    step(1, 1, 0, 1);
    chk("R7 both set", status, 16'h0005);
    step(0, 0, 0, 1);
    chk("R6 both cleared", status, 16'h0000);

    // R5 busy follows, clear has no effect, enable reset value 0
    step(0, 0, 1, 1);
    chk("R5 busy set despite clear", status, 16'h0002);
    chk("R8 busy masked", {15'd0, alarm}, 16'h0000);
    en_b = 1; #1;
    chk("R8 busy enabled", {15'd0, alarm}, 16'h0001);
    @(negedge clk);
    step(0, 0, 0, 0);
    chk("R5 busy released", status, 16'h0000);
    check_all("R5 directed");

    // constrained random
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 3000; i++) begin
      en_t = $urandom % 2;
      en_b = $urandom % 2;
      en_c = $urandom % 2;
      step(($urandom % 12) == 0, ($urandom % 10) == 0,
           ($urandom % 3) == 0, ($urandom % 6) == 0);
      check_all("R2 R3 R4 R5 R6 R7 R8 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule